// File: doc/BRIEF.md
# Multicore Interrupt Routing Controller

This block gathers level-sensitive interrupt sources and delivers them to up to four processor cores. Software programs it through a small register port. Each shared source has one global enable bit and a per-core mask bit. Both are changed by writing the source number to a dedicated set or clear register, so no read-modify-write is needed. A control word for each source selects which cores receive it as a normal interrupt (IRQ) and which receive it as a fast interrupt (FIQ).

Two source numbers are private to each core. They take a separate level input per core. Only the reading core's mask gates them. Global enables and routing are ignored for them. Sources 0 and 1 carry the summaries of the inter-processor and message-signalled doorbells; the block treats them as ordinary shared sources.

Each core reads an acknowledge register. It returns the lowest-numbered source that is pending and deliverable to that core as an IRQ, or a spurious code when none is. The core is identified by a core-id field on the register port, and that field also selects which banked mask a mask write changes.

Top module: `irq_route_ctrl`

## Requirements
- R1: After reset every global enable is clear, every per-core mask bit is set, every routing field is zero, `core_irq` and `core_fiq` are low, and an acknowledge read returns 1023.
- R2: A write to offset 0x030 sets the global enable of the source whose number is in `bus_wdata[9:0]`, and a write to 0x034 clears it. A number at or above NUM_SRC changes nothing.
- R3: A write to 0x048 masks the source numbered in `bus_wdata[9:0]`, and a write to 0x04C unmasks it. Only the mask bank of the core given on `bus_core` changes. A number at or above NUM_SRC changes nothing.
- R4: Source n has a control word at 0x100 + 4*n. Bit 8+c routes the source to core c as FIQ, and bit c routes it to core c as IRQ. A read returns these eight bits, and all other bits read zero.
- R5: A shared source raises `core_irq[c]` when its level is high, its global enable is set, core c has it unmasked, and its IRQ route bit c is set. `core_irq` is registered and follows the inputs one clock edge later.
- R6: `core_fiq[c]` follows the same gating as R5, using the FIQ route bit c in place of the IRQ route bit. It is also registered.
- R7: A read of 0x044 returns, in bits [9:0], the lowest-numbered source raising IRQ for the core on `bus_core`, or 1023 when there is none. The read has no side effect.
- R8: Private sources 3 and 5 take their levels from `prv_lvl` (bit 2c for source 3 and bit 2c+1 for source 5 of core c). They are gated only by core c's mask. Global enables, routing and `src_lvl` bits 3 and 5 have no effect on them, and they never raise FIQ.
- R9: A read of 0x000 returns NUM_SRC in bits [11:2].
- R10: Sources are level-sensitive: when a source input falls, the source stops being pending, and no pending state is kept.
- R11: `bus_rdata` is loaded at the clock edge that takes a read request, and it holds its value until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_req | input | 1 | Register access request, one cycle per access |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_core | input | 2 | Number of the requesting core |
| bus_addr | input | ADDR_W | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, registered |
| src_lvl | input | NUM_SRC | Levels of the shared sources |
| prv_lvl | input | 2*NUM_CORE | Levels of the private sources, two per core |
| core_irq | output | NUM_CORE | IRQ request to each core |
| core_fiq | output | NUM_CORE | FIQ request to each core |

## Verification
Read data is due one rising edge after the request. A change on a source input reaches `core_irq` and `core_fiq` one edge later. A register write takes two edges to reach them: one to update the state and one for the output register. The bench drives every input on a falling edge. It samples read data on the next falling edge, and it samples interrupt outputs only after at least two further falling edges. It never samples on the edge that updates the value.

// File: rtl/irq_route_pkg.sv
package irq_route_pkg;

   localparam int IDX_W = 10;
   localparam logic [IDX_W-1:0] SPURIOUS = 10'h3FF;

   localparam logic [11:0] OFS_CTRL     = 12'h000;
   localparam logic [11:0] OFS_EN_SET   = 12'h030;
   localparam logic [11:0] OFS_EN_CLR   = 12'h034;
   localparam logic [11:0] OFS_ACK      = 12'h044;
   localparam logic [11:0] OFS_MSK_SET  = 12'h048;
   localparam logic [11:0] OFS_MSK_CLR  = 12'h04C;
   localparam int          OFS_SRC_BASE = 'h100;

   typedef struct packed {
      logic [3:0] fiq;
      logic [3:0] irq;
   } route_t;

endpackage

// File: rtl/irq_route_regs.sv
module irq_route_regs
   import irq_route_pkg::*;
#(
   parameter int NUM_SRC  = 32,
   parameter int NUM_CORE = 4,
   parameter int ADDR_W   = 12
) (
   input  logic                                clk,
   input  logic                                rst_n,
   input  logic                                bus_req,
   input  logic                                bus_we,
   input  logic [1:0]                          bus_core,
   input  logic [ADDR_W-1:0]                   bus_addr,
   input  logic [31:0]                         bus_wdata,
   input  logic [NUM_CORE-1:0][IDX_W-1:0]      ack_idx,
   output logic [31:0]                         bus_rdata,
   output logic [NUM_SRC-1:0]                  en_q,
   output logic [NUM_CORE-1:0][NUM_SRC-1:0]    msk_q,
   output route_t [NUM_SRC-1:0]                route_q
);

   localparam int SRC_W   = $clog2(NUM_SRC);
   localparam int WIN_END = OFS_SRC_BASE + 4 * NUM_SRC;

   logic              wr, rd;
   logic [IDX_W-1:0]  idx;
   logic              idx_ok;
   logic [SRC_W-1:0]  idx_s;
   logic              win_hit;
   logic [SRC_W-1:0]  src_sel;
   logic [ADDR_W-1:0] win_ofs;
   logic [31:0]       rd_nx;

   assign wr      = bus_req & bus_we;
   assign rd      = bus_req & ~bus_we;
   assign idx     = bus_wdata[IDX_W-1:0];
   assign idx_ok  = (idx < IDX_W'(NUM_SRC));
   assign idx_s   = idx[SRC_W-1:0];
   assign win_hit = (bus_addr >= ADDR_W'(OFS_SRC_BASE)) &&
                    (bus_addr <  ADDR_W'(WIN_END)) &&
                    (bus_addr[1:0] == 2'b00);
   assign win_ofs = bus_addr - ADDR_W'(OFS_SRC_BASE);
   assign src_sel = win_ofs[SRC_W+1:2];

   // global enables
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         en_q <= '0;
      end else if (wr && idx_ok) begin
         if (bus_addr == ADDR_W'(OFS_EN_SET))
            en_q[idx_s] <= 1'b1;
         else if (bus_addr == ADDR_W'(OFS_EN_CLR))
            en_q[idx_s] <= 1'b0;
      end
   end

   // banked per-core masks
   for (genvar c = 0; c < NUM_CORE; c++) begin : g_mask
      logic [NUM_SRC-1:0] m_q;
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            m_q <= '1;
         end else if (wr && idx_ok && bus_core == 2'(c)) begin
            if (bus_addr == ADDR_W'(OFS_MSK_SET))
               m_q[idx_s] <= 1'b1;
            else if (bus_addr == ADDR_W'(OFS_MSK_CLR))
               m_q[idx_s] <= 1'b0;
         end
      end
      assign msk_q[c] = m_q;
   end

   // per-source routing words
   for (genvar n = 0; n < NUM_SRC; n++) begin : g_route
      route_t r_q;
      always_ff @(posedge clk) begin
         if (!rst_n)
            r_q <= '0;
         else if (wr && win_hit && src_sel == SRC_W'(n))
            r_q <= '{fiq: bus_wdata[11:8], irq: bus_wdata[3:0]};
      end
      assign route_q[n] = r_q;
   end

   // read multiplexer
   always_comb begin
      rd_nx = '0;
      if (bus_addr == ADDR_W'(OFS_CTRL)) begin
         rd_nx[11:2] = IDX_W'(NUM_SRC);
      end else if (bus_addr == ADDR_W'(OFS_ACK)) begin
         rd_nx[IDX_W-1:0] = SPURIOUS;
         for (int c = 0; c < NUM_CORE; c++)
            if (bus_core == 2'(c)) rd_nx[IDX_W-1:0] = ack_idx[c];
      end else if (win_hit) begin
         for (int n = 0; n < NUM_SRC; n++)
            if (src_sel == SRC_W'(n))
               rd_nx = {20'b0, route_q[n].fiq, 4'b0, route_q[n].irq};
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n)
         bus_rdata <= {22'b0, SPURIOUS};
      else if (rd)
         bus_rdata <= rd_nx;
   end

endmodule

// File: rtl/irq_route_pick.sv
module irq_route_pick
   import irq_route_pkg::*;
#(
   parameter int NUM_SRC = 32
) (
   input  logic [NUM_SRC-1:0] req_vec,
   output logic [IDX_W-1:0]   idx
);

   // scan downward so the lowest set bit is the last assignment
   always_comb begin
      idx = SPURIOUS;
      for (int n = NUM_SRC - 1; n >= 0; n--)
         if (req_vec[n]) idx = IDX_W'(n);
   end

endmodule

// File: rtl/irq_route_ctrl.sv
module irq_route_ctrl
   import irq_route_pkg::*;
#(
   parameter int NUM_SRC  = 32,
   parameter int NUM_CORE = 4,
   parameter int ADDR_W   = 12,
   parameter int PRIV_LO  = 3,
   parameter int PRIV_HI  = 5
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  bus_req,
   input  logic                  bus_we,
   input  logic [1:0]            bus_core,
   input  logic [ADDR_W-1:0]     bus_addr,
   input  logic [31:0]           bus_wdata,
   output logic [31:0]           bus_rdata,
   input  logic [NUM_SRC-1:0]    src_lvl,
   input  logic [2*NUM_CORE-1:0] prv_lvl,
   output logic [NUM_CORE-1:0]   core_irq,
   output logic [NUM_CORE-1:0]   core_fiq
);

   if (NUM_CORE < 1 || NUM_CORE > 4) begin : g_bad_core
      $error("NUM_CORE must be 1..4");
   end
   if (NUM_SRC <= PRIV_HI || NUM_SRC >= 1023) begin : g_bad_src
      $error("NUM_SRC out of range");
   end
   if (ADDR_W < 12 || OFS_SRC_BASE + 4 * NUM_SRC > (1 << ADDR_W)) begin : g_bad_addr
      $error("ADDR_W too small for the source window");
   end

   logic [NUM_SRC-1:0]               en_q;
   logic [NUM_CORE-1:0][NUM_SRC-1:0] msk_q;
   route_t [NUM_SRC-1:0]             route_q;
   logic [NUM_CORE-1:0][IDX_W-1:0]   ack_idx;
   logic [NUM_CORE-1:0][NUM_SRC-1:0] irq_vec;
   logic [NUM_CORE-1:0][NUM_SRC-1:0] fiq_vec;

   irq_route_regs #(
      .NUM_SRC (NUM_SRC),
      .NUM_CORE(NUM_CORE),
      .ADDR_W  (ADDR_W)
   ) u_regs (
      .clk      (clk),
      .rst_n    (rst_n),
      .bus_req  (bus_req),
      .bus_we   (bus_we),
      .bus_core (bus_core),
      .bus_addr (bus_addr),
      .bus_wdata(bus_wdata),
      .ack_idx  (ack_idx),
      .bus_rdata(bus_rdata),
      .en_q     (en_q),
      .msk_q    (msk_q),
      .route_q  (route_q)
   );

   for (genvar c = 0; c < NUM_CORE; c++) begin : g_core
      for (genvar n = 0; n < NUM_SRC; n++) begin : g_src
         if (n == PRIV_LO) begin : g_plo
            assign irq_vec[c][n] = prv_lvl[2*c] & ~msk_q[c][n];
            assign fiq_vec[c][n] = 1'b0;
         end else if (n == PRIV_HI) begin : g_phi
            assign irq_vec[c][n] = prv_lvl[2*c+1] & ~msk_q[c][n];
            assign fiq_vec[c][n] = 1'b0;
         end else begin : g_shr
            logic live;
            assign live          = src_lvl[n] & en_q[n] & ~msk_q[c][n];
            assign irq_vec[c][n] = live & route_q[n].irq[c];
            assign fiq_vec[c][n] = live & route_q[n].fiq[c];
         end
      end

      irq_route_pick #(.NUM_SRC(NUM_SRC)) u_pick (
         .req_vec(irq_vec[c]),
         .idx    (ack_idx[c])
      );

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            core_irq[c] <= 1'b0;
            core_fiq[c] <= 1'b0;
         end else begin
            core_irq[c] <= |irq_vec[c];
            core_fiq[c] <= |fiq_vec[c];
         end
      end
   end

endmodule

// File: rtl/irq_route_chk.sv
module irq_route_chk
   import irq_route_pkg::*;
#(
   parameter int NUM_SRC  = 32,
   parameter int NUM_CORE = 4,
   parameter int ADDR_W   = 12
) (
   input logic                  clk,
   input logic                  rst_n,
   input logic                  bus_req,
   input logic                  bus_we,
   input logic [ADDR_W-1:0]     bus_addr,
   input logic [31:0]           bus_rdata,
   input logic [NUM_SRC-1:0]    src_lvl,
   input logic [2*NUM_CORE-1:0] prv_lvl,
   input logic [NUM_CORE-1:0]   core_irq,
   input logic [NUM_CORE-1:0]   core_fiq
);

   logic ack_rd, ctl_rd, any_rd, all_quiet;
   assign ack_rd    = bus_req && !bus_we && bus_addr == ADDR_W'(OFS_ACK);
   assign ctl_rd    = bus_req && !bus_we && bus_addr == ADDR_W'(OFS_CTRL);
   assign any_rd    = bus_req && !bus_we;
   assign all_quiet = (src_lvl == '0) && (prv_lvl == '0);

   AST_IRQ_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
      (|core_irq) |-> $past(!all_quiet));                               // R5
   AST_FIQ_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
      (|core_fiq) |-> $past(|src_lvl));                                 // R6
   AST_ACK_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      ack_rd |=> (bus_rdata[9:0] < 10'(NUM_SRC) || bus_rdata[9:0] == SPURIOUS)); // R7
   AST_ACK_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_n)
      (ack_rd && all_quiet) |=> bus_rdata[9:0] == SPURIOUS);            // R7
   AST_CTRL_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
      ctl_rd |=> bus_rdata[11:2] == 10'(NUM_SRC));                      // R9
   AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !any_rd |=> $stable(bus_rdata));                                  // R11

endmodule

bind irq_route_ctrl irq_route_chk #(
   .NUM_SRC (NUM_SRC),
   .NUM_CORE(NUM_CORE),
   .ADDR_W  (ADDR_W)
) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .bus_req  (bus_req),
   .bus_we   (bus_we),
   .bus_addr (bus_addr),
   .bus_rdata(bus_rdata),
   .src_lvl  (src_lvl),
   .prv_lvl  (prv_lvl),
   .core_irq (core_irq),
   .core_fiq (core_fiq)
);

// File: tb/irq_route_ctrl_tb_top.sv
`timescale 1ns/1ps
module irq_route_ctrl_tb_top;

   localparam int NS = 32;
   localparam int NC = 4;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          bus_req = 1'b0;
   logic          bus_we = 1'b0;
   logic [1:0]    bus_core = 2'd0;
   logic [11:0]   bus_addr = '0;
   logic [31:0]   bus_wdata = '0;
   logic [31:0]   bus_rdata;
   logic [NS-1:0] src_lvl = '0;
   logic [2*NC-1:0] prv_lvl = '0;
   logic [NC-1:0] core_irq;
   logic [NC-1:0] core_fiq;

   int n_chk = 0;
   int n_fail = 0;

   always #2.5 clk = ~clk;

   irq_route_ctrl dut_i (
      .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_we(bus_we),
      .bus_core(bus_core), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
      .bus_rdata(bus_rdata), .src_lvl(src_lvl), .prv_lvl(prv_lvl),
      .core_irq(core_irq), .core_fiq(core_fiq)
   );

   task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
      end
   endtask

   task automatic settle(int k);
      repeat (k) @(negedge clk);
   endtask

   task automatic wr(logic [11:0] a, logic [31:0] d, logic [1:0] c);
      @(negedge clk);
      bus_req = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d; bus_core = c;
      @(negedge clk);
      bus_req = 1'b0; bus_we = 1'b0;
   endtask

   task automatic rd(logic [11:0] a, logic [1:0] c, output logic [31:0] d);
      @(negedge clk);
      bus_req = 1'b1; bus_we = 1'b0; bus_addr = a; bus_core = c;
      @(negedge clk);
      bus_req = 1'b0;
      d = bus_rdata;
   endtask

   function automatic logic [11:0] ctl(int n);
      return 12'(32'h100 + 4 * n);
   endfunction

   task automatic t_reset();
      logic [31:0] d;
      chk("R1 irq", 32'(core_irq), 32'h0);
      chk("R1 fiq", 32'(core_fiq), 32'h0);
      rd(12'h044, 2'd0, d);  chk("R1 ack spurious", d, 32'h3FF);
      rd(12'h000, 2'd0, d);  chk("R9 source count", 32'(d[11:2]), 32'(NS));
      rd(ctl(7), 2'd0, d);   chk("R1 R4 route zero", d, 32'h0);
      src_lvl = '1; prv_lvl = '1;
      settle(3);
      chk("R1 all gated irq", 32'(core_irq), 32'h0);
      chk("R1 all gated fiq", 32'(core_fiq), 32'h0);
      src_lvl = '0; prv_lvl = '0;
      settle(2);
   endtask

   task automatic t_route();
      logic [31:0] d;
      src_lvl[9] = 1'b1;
      wr(ctl(9), 32'hABCD_F3F3, 2'd0);
      rd(ctl(9), 2'd0, d);   chk("R4 readback", d, 32'h0000_0303);
      wr(12'h030, 32'd9, 2'd0);
      wr(12'h04C, 32'd9, 2'd1);
      settle(2);
      chk("R5 R3 irq only core1", 32'(core_irq), 32'h2);
      chk("R6 fiq only core1", 32'(core_fiq), 32'h2);
      rd(12'h044, 2'd1, d);  chk("R7 ack core1", d, 32'd9);
      rd(12'h044, 2'd0, d);  chk("R3 ack core0 masked", d, 32'h3FF);
      wr(12'h034, 32'd9, 2'd0);
      settle(2);
      chk("R2 clear enable", 32'(core_irq), 32'h0);
      wr(12'h030, 32'd9, 2'd0);
      settle(2);
      chk("R2 set enable again", 32'(core_irq), 32'h2);
      src_lvl[9] = 1'b0;
      settle(2);
      chk("R10 level drop irq", 32'(core_irq), 32'h0);
      chk("R10 level drop fiq", 32'(core_fiq), 32'h0);
      rd(12'h044, 2'd1, d);  chk("R10 ack after drop", d, 32'h3FF);
   endtask

   task automatic t_priority();
      logic [31:0] d;
      wr(ctl(20), 32'h2, 2'd0);
      wr(12'h030, 32'd20, 2'd0);
      wr(12'h04C, 32'd20, 2'd1);
      src_lvl[9] = 1'b1; src_lvl[20] = 1'b1;
      settle(2);
      rd(12'h044, 2'd1, d);  chk("R7 lowest wins", d, 32'd9);
      rd(12'h044, 2'd1, d);  chk("R7 no side effect", d, 32'd9);
      src_lvl[9] = 1'b0;
      settle(2);
      rd(12'h044, 2'd1, d);  chk("R7 next source", d, 32'd20);
      settle(4);
      chk("R11 rdata holds", bus_rdata, 32'd20);
      src_lvl[20] = 1'b0;
      settle(2);
   endtask

   task automatic t_private();
      logic [31:0] d;
      prv_lvl[4] = 1'b1;
      settle(2);
      chk("R8 private masked", 32'(core_irq), 32'h0);
      wr(12'h04C, 32'd3, 2'd2);
      settle(2);
      chk("R8 private no enable needed", 32'(core_irq), 32'h4);
      rd(12'h044, 2'd2, d);  chk("R8 ack private", d, 32'd3);
      src_lvl[3] = 1'b1;
      wr(12'h030, 32'd3, 2'd0);
      wr(ctl(3), 32'h0F0F, 2'd0);
      wr(12'h04C, 32'd3, 2'd0);
      settle(2);
      chk("R8 shared level ignored", 32'(core_irq), 32'h4);
      chk("R8 no fiq", 32'(core_fiq), 32'h0);
      prv_lvl[7] = 1'b1;
      wr(12'h04C, 32'd5, 2'd3);
      settle(2);
      chk("R8 second private", 32'(core_irq), 32'hC);
      rd(12'h044, 2'd3, d);  chk("R8 ack core3", d, 32'd5);
      prv_lvl = '0; src_lvl = '0;
      settle(2);
   endtask

   task automatic t_range();
      src_lvl[8] = 1'b1;
      wr(ctl(8), 32'h1, 2'd0);
      wr(12'h04C, 32'd8, 2'd0);
      wr(12'h030, 32'd40, 2'd0);
      settle(2);
      chk("R2 index out of range", 32'(core_irq), 32'h0);
      wr(12'h030, 32'd8, 2'd0);
      settle(2);
      chk("R2 index in range", 32'(core_irq), 32'h1);
      wr(12'h048, 32'd40, 2'd0);
      settle(2);
      chk("R3 mask out of range", 32'(core_irq), 32'h1);
      wr(12'h048, 32'd8, 2'd1);
      settle(2);
      chk("R3 other core bank", 32'(core_irq), 32'h1);
      wr(12'h048, 32'd8, 2'd0);
      settle(2);
      chk("R3 own bank masks", 32'(core_irq), 32'h0);
      src_lvl = '0;
   endtask

   initial begin
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      settle(1);
      t_reset();
      t_route();
      t_priority();
      t_private();
      t_range();
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
   end

endmodule